// File: doc/BRIEF.md
# Prioritized Address-Window Chip-Select Decoder

This block sits beside an external bus controller and turns each external access into a chip select and a bus-cycle length. It holds no registers of its own for configuration. Four address windows come in as a base, a size code and an enable. Five bus-configuration words come in as well, one for each window and one for the region that no window covers. When the controller raises its address strobe (ALE, a synchronous strobe sampled on the CPU clock), the decoder matches the current 24-bit address against the windows. It resolves overlaps, latches the winning configuration and pulls the matching active-low chip select low. It then counts the configured wait states and, when the window asks for it, waits for the READY input to reach that window's active level. It raises a one-cycle done indication and releases the chip select on the following clock edge.

Chip selects either change on the clock edge that samples the strobe, or, by default, half a clock later on the falling edge. The block also reports how many upper segment address lines the selected address-space size needs. That count is capped when a shared peripheral claims the top pins.

Top module: `cs_window_decoder`

## Requirements
- R1: An enabled window with base field B (address bits 23:12) and size code S covers the 2^(12+S) bytes starting at B*4096 with its low 12+S bits cleared. A size code of 12 or more covers the whole space, and a disabled window covers nothing. Window k (k = 1..4) drives cs_n_o bit k-1 low.
- R2: An address covered by no enabled window selects the default set, driving cs_n_o bit 4 low with configuration word 4.
- R3: Where windows 2 and 1 overlap, window 2 wins. Where windows 4 and 3 overlap, window 4 wins.
- R4: Where a window of the upper pair (3 or 4) overlaps a window of the lower pair (1 or 2), the upper-pair window wins.
- R5: At most one chip select is low at any time. All are high while no access runs. The chip select returns high on the clock edge after the cycle in which done_o is high.
- R6: With cs_fast_i high, the chip select changes on the rising clock edge that first samples ale_i high (and on the edge that ends the cycle). With cs_fast_i low, each change appears half a clock later, on the following falling edge.
- R7: Configuration word k is cfg_i[6k+5:6k], with bits [3:0] a wait-state count W, bit 4 a ready enable and bit 5 the ready active level. With ready disabled, done_o is high in cycle W+1 of the access (counting the first cycle after the strobe edge as 1), and is high for exactly one cycle.
- R8: With ready enabled, done_o stays low after the wait states until rdy_i equals the selected window's active level. With ready disabled, rdy_i has no effect.
- R9: A rising ale_i during a running access is ignored. The selected chip select and the cycle length stay as they were.
- R10: space_sel_i = 0, 1, 2, 3 (16M, 1M, 256K, 64K bytes) gives seg_lines_o = 8, 4, 2, 0.
- R11: With can_i high, seg_lines_o never exceeds 4.
- R12: During and right after reset, all chip selects are high and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 24 | Bus address of the access |
| ale_i | input | 1 | Address strobe; rising sample starts an access |
| rdy_i | input | 1 | Ready input from the slow device |
| win_en_i | input | 4 | Enable per window |
| win_base_i | input | 48 | Base field (address bits 23:12) per window, window k at [12k-1:12k-12] |
| win_size_i | input | 16 | Size code per window, window k at [4k-1:4k-4] |
| cfg_i | input | 30 | Five configuration words, 6 bits each, word 4 is the default set |
| cs_fast_i | input | 1 | 1: chip select on the strobe edge; 0: half a clock later |
| space_sel_i | input | 2 | Address-space size select |
| can_i | input | 1 | Shared peripheral claims the top segment pins |
| cs_n_o | output | 5 | Active-low chip selects, bit 4 for the default region |
| seg_lines_o | output | 4 | Number of segment address lines in use |
| done_o | output | 1 | Bus cycle ends this cycle |

## Verification
A wrong match mask or a wrong priority branch shows at once. In the cycle after the strobe, a chip select other than the one the arithmetic window model predicts goes low, so the sweeps over overlapping layouts report it on the first affected address. A wait counter that is off by one, or a ready comparison with the wrong sense, moves done_o by one or more cycles, and the per-cycle done check catches it. A select register that reloads mid-access changes the low chip select within one cycle of the second strobe. A lost falling-edge stage shows as a chip select that is already low at the quarter-cycle sample.

// File: rtl/csd_pkg.sv
`timescale 1ns/1ps
package csd_pkg;
  localparam int NWIN       = 4;
  localparam int NSET       = NWIN + 1;
  localparam int WAIT_W     = 4;
  localparam int CFG_W      = WAIT_W + 2;
  localparam int SEL_W      = $clog2(NSET);
  localparam int NPAIR      = NWIN / 2;

  typedef struct packed {
    logic              rdy_pol;
    logic              rdy_en;
    logic [WAIT_W-1:0] waits;
  } bus_cfg_t;
endpackage

// File: rtl/csd_reset_sync.sv
`timescale 1ns/1ps
module csd_reset_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/csd_window_match.sv
`timescale 1ns/1ps
module csd_window_match #(
  parameter int BASE_W = 12,
  parameter int SIZE_W = 4
) (
  input  logic [BASE_W-1:0] addr_hi_i,
  input  logic              en_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              hit_o
);
  logic [BASE_W-1:0] keep_mask;

  // bits below the window size are don't-care in the comparison
  always_comb begin
    for (int b = 0; b < BASE_W; b++) begin
      keep_mask[b] = (b >= int'(size_i));
    end
  end

  assign hit_o = en_i && (((addr_hi_i ^ base_i) & keep_mask) == '0);
endmodule

// File: rtl/csd_prio_sel.sv
`timescale 1ns/1ps
module csd_prio_sel
  import csd_pkg::*;
(
  input  logic [NWIN-1:0]  hit_i,
  output logic [SEL_W-1:0] sel_o
);
  logic found;

  // pairs are scanned from the top; inside a pair the odd window wins
  always_comb begin
    sel_o = SEL_W'(NWIN);
    found = 1'b0;
    for (int p = NPAIR - 1; p >= 0; p--) begin
      if (!found) begin
        if (hit_i[2*p+1]) begin
          sel_o = SEL_W'(2*p+1);
          found = 1'b1;
        end else if (hit_i[2*p]) begin
          sel_o = SEL_W'(2*p);
          found = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/csd_cycle_ctrl.sv
`timescale 1ns/1ps
module csd_cycle_ctrl
  import csd_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_n_i,
  input  logic                  ale_i,
  input  logic                  rdy_i,
  input  logic                  cs_fast_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [NSET*CFG_W-1:0] cfg_i,
  output logic [NSET-1:0]       cs_n_o,
  output logic                  done_o,
  output logic                  busy_o,
  output logic [SEL_W-1:0]      sel_q_o,
  output logic                  act_rdy_en_o,
  output logic                  act_rdy_pol_o
);
  bus_cfg_t          cfg_arr [NSET];
  bus_cfg_t          act_cfg;
  bus_cfg_t          new_cfg;

  logic              ale_q;
  logic              busy_q, busy_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              ctl_en;
  logic              ale_rise;
  logic              rdy_ok;
  logic [NSET-1:0]   cs_early_n;
  logic [NSET-1:0]   cs_late_q;

  for (genvar k = 0; k < NSET; k++) begin : g_cfg
    assign cfg_arr[k] = bus_cfg_t'(cfg_i[k*CFG_W +: CFG_W]);
  end

  always_comb begin
    act_cfg = '0;
    new_cfg = '0;
    for (int k = 0; k < NSET; k++) begin
      if (sel_q == SEL_W'(k)) act_cfg = cfg_arr[k];
      if (sel_i == SEL_W'(k)) new_cfg = cfg_arr[k];
    end
  end

  assign ale_rise = ale_i && !ale_q;
  assign rdy_ok   = !act_cfg.rdy_en || (rdy_i == act_cfg.rdy_pol);
  assign done_o   = busy_q && (cnt_q == '0) && rdy_ok;

  // next-state
  always_comb begin
    busy_d = busy_q;
    sel_d  = sel_q;
    cnt_d  = cnt_q;
    if (!busy_q) begin
      if (ale_rise) begin
        busy_d = 1'b1;
        sel_d  = sel_i;
        cnt_d  = new_cfg.waits;
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else if (rdy_ok) begin
      busy_d = 1'b0;
    end
  end

  assign ctl_en = busy_q || ale_rise;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ale_q  <= 1'b0;
      busy_q <= 1'b0;
      sel_q  <= '0;
      cnt_q  <= '0;
    end else begin
      ale_q <= ale_i;
      if (ctl_en) begin
        busy_q <= busy_d;
        sel_q  <= sel_d;
        cnt_q  <= cnt_d;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NSET; k++) begin
      cs_early_n[k] = !(busy_q && (sel_q == SEL_W'(k)));
    end
  end

  // half-cycle delayed copy for the default chip-select timing
  always_ff @(negedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cs_late_q <= '1;
    end else begin
      cs_late_q <= cs_early_n;
    end
  end

  assign cs_n_o        = cs_fast_i ? cs_early_n : cs_late_q;
  assign busy_o        = busy_q;
  assign sel_q_o       = sel_q;
  assign act_rdy_en_o  = act_cfg.rdy_en;
  assign act_rdy_pol_o = act_cfg.rdy_pol;
endmodule

// File: rtl/cs_window_decoder.sv
`timescale 1ns/1ps
module cs_window_decoder
  import csd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int GRAN_W = 12,
  parameter int SIZE_W = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_n_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic                         ale_i,
  input  logic                         rdy_i,
  input  logic [NWIN-1:0]              win_en_i,
  input  logic [NWIN*(ADDR_W-GRAN_W)-1:0] win_base_i,
  input  logic [NWIN*SIZE_W-1:0]       win_size_i,
  input  logic [NSET*CFG_W-1:0]        cfg_i,
  input  logic                         cs_fast_i,
  input  logic [1:0]                   space_sel_i,
  input  logic                         can_i,
  output logic [NSET-1:0]              cs_n_o,
  output logic [3:0]                   seg_lines_o,
  output logic                         done_o
);
  localparam int BASE_W   = ADDR_W - GRAN_W;
  localparam int SEG_MAX  = ADDR_W - 16;
  localparam int SEG_SHARED = SEG_MAX / 2;

  logic             rst_n_s;
  logic [NWIN-1:0]  hit;
  logic [SEL_W-1:0] sel_w;
  logic             busy_w;
  logic [SEL_W-1:0] sel_q_w;
  logic             act_rdy_en_w;
  logic             act_rdy_pol_w;
  logic [3:0]       seg_raw;

  csd_reset_sync u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n_s)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    csd_window_match #(
      .BASE_W (BASE_W),
      .SIZE_W (SIZE_W)
    ) u_match (
      .addr_hi_i (addr_i[ADDR_W-1:GRAN_W]),
      .en_i      (win_en_i[w]),
      .base_i    (win_base_i[w*BASE_W +: BASE_W]),
      .size_i    (win_size_i[w*SIZE_W +: SIZE_W]),
      .hit_o     (hit[w])
    );
  end

  csd_prio_sel u_prio (
    .hit_i (hit),
    .sel_o (sel_w)
  );

  csd_cycle_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_n_i       (rst_n_s),
    .ale_i         (ale_i),
    .rdy_i         (rdy_i),
    .cs_fast_i     (cs_fast_i),
    .sel_i         (sel_w),
    .cfg_i         (cfg_i),
    .cs_n_o        (cs_n_o),
    .done_o        (done_o),
    .busy_o        (busy_w),
    .sel_q_o       (sel_q_w),
    .act_rdy_en_o  (act_rdy_en_w),
    .act_rdy_pol_o (act_rdy_pol_w)
  );

  always_comb begin
    case (space_sel_i)
      2'd0:    seg_raw = 4'(SEG_MAX);
      2'd1:    seg_raw = 4'(SEG_SHARED);
      2'd2:    seg_raw = 4'(SEG_SHARED / 2);
      default: seg_raw = 4'd0;
    endcase
    seg_lines_o = (can_i && (seg_raw > 4'(SEG_SHARED))) ? 4'(SEG_SHARED) : seg_raw;
  end
endmodule

// File: rtl/csd_checker.sv
`timescale 1ns/1ps
module csd_checker
  import csd_pkg::*;
(
  input logic             clk_i,
  input logic             rst_n_i,
  input logic [NSET-1:0]  cs_n_o,
  input logic             done_o,
  input logic             cs_fast_i,
  input logic             rdy_i,
  input logic             can_i,
  input logic [3:0]       seg_lines_o,
  input logic             busy_q,
  input logic [SEL_W-1:0] sel_q,
  input logic             act_rdy_en,
  input logic             act_rdy_pol
);
  AST_ONE_CS_LOW: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0(~cs_n_o)); // R5

  AST_IDLE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |=> (!cs_fast_i || (&cs_n_o))); // R5

  AST_DONE_AT_READY_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (done_o && act_rdy_en) |-> (rdy_i == act_rdy_pol)); // R8

  AST_SEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (busy_q && !done_o) |=> (busy_q && $stable(sel_q))); // R9

  AST_SEG_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (seg_lines_o == 4'd0) || (seg_lines_o == 4'd2) || (seg_lines_o == 4'd4) || (seg_lines_o == 4'd8)); // R10

  AST_SEG_SHARED_CAP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    can_i |-> (seg_lines_o <= 4'd4)); // R11
endmodule

bind cs_window_decoder csd_checker u_chk (
  .clk_i       (clk_i),
  .rst_n_i     (rst_n_i),
  .cs_n_o      (cs_n_o),
  .done_o      (done_o),
  .cs_fast_i   (cs_fast_i),
  .rdy_i       (rdy_i),
  .can_i       (can_i),
  .seg_lines_o (seg_lines_o),
  .busy_q      (busy_w),
  .sel_q       (sel_q_w),
  .act_rdy_en  (act_rdy_en_w),
  .act_rdy_pol (act_rdy_pol_w)
);

// File: tb/tb_cs_window_decoder.sv
`timescale 1ns/1ps
module tb_cs_window_decoder;
  logic        clk;
  logic        rst_n;
  logic [23:0] addr;
  logic        ale;
  logic        rdy;
  logic [3:0]  win_en;
  logic [47:0] win_base;
  logic [15:0] win_size;
  logic [29:0] cfg;
  logic        cs_fast;
  logic [1:0]  space_sel;
  logic        can_en;
  logic [4:0]  cs_n;
  logic [3:0]  seg_lines;
  logic        done;

  int checks = 0;
  int errors = 0;

  int bbase [4];
  int bsize [4];
  bit ben   [4];
  int bwait [5];
  bit ren   [5];
  bit rpol  [5];

  cs_window_decoder dut (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .addr_i      (addr),
    .ale_i       (ale),
    .rdy_i       (rdy),
    .win_en_i    (win_en),
    .win_base_i  (win_base),
    .win_size_i  (win_size),
    .cfg_i       (cfg),
    .cs_fast_i   (cs_fast),
    .space_sel_i (space_sel),
    .can_i       (can_en),
    .cs_n_o      (cs_n),
    .seg_lines_o (seg_lines),
    .done_o      (done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply_cfg();
    for (int k = 0; k < 4; k++) begin
      win_base[k*12 +: 12] = 12'(bbase[k]);
      win_size[k*4 +: 4]   = 4'(bsize[k]);
      win_en[k]            = ben[k];
    end
    for (int k = 0; k < 5; k++) begin
      cfg[k*6 +: 6] = {rpol[k], ren[k], 4'(bwait[k])};
    end
  endtask

  // arithmetic window model with the pairwise precedence
  function automatic int exp_sel(input logic [23:0] a);
    bit h [4];
    for (int k = 0; k < 4; k++) begin
      int sh;
      sh = 12 + bsize[k];
      if (!ben[k]) h[k] = 1'b0;
      else if (bsize[k] >= 12) h[k] = 1'b1;
      else h[k] = ((int'(a) >> sh) == ((bbase[k] << 12) >> sh));
    end
    if (h[3]) return 3;
    if (h[2]) return 2;
    if (h[1]) return 1;
    if (h[0]) return 0;
    return 4;
  endfunction

  task automatic do_access(input logic [23:0] a, input int extra, input int glitch,
                           input logic [23:0] alt, input string tag);
    int sel, last;
    bit en, pol;
    logic [4:0] expcs;
    sel   = exp_sel(a);
    en    = ren[sel];
    pol   = rpol[sel];
    last  = bwait[sel] + (en ? extra : 0);
    expcs = ~(5'b00001 << sel);
    @(posedge clk); #2; ale = 1'b1; addr = a;
    @(posedge clk); #2;
    for (int i = 0; ; i++) begin
      rdy = (en && i >= last) ? pol : ~pol;
      ale = (i == glitch);
      if (i == glitch) addr = alt;
      #3;
      chk({tag, " R6 cs early sample"}, 32'(cs_n), 32'((cs_fast || i > 0) ? expcs : 5'h1f));
      chk({tag, " R7 R8 done"}, 32'(done), 32'(i == last));
      #10;
      chk({tag, " R5 cs"}, 32'(cs_n), 32'(expcs));
      if (i == last) break;
      if (i > 40) break;
      @(posedge clk); #2;
    end
    ale = 1'b0;
    @(posedge clk); #3;
    chk({tag, " R5 R6 release"}, 32'(cs_n), 32'(cs_fast ? 5'h1f : expcs));
    chk({tag, " R7 single done"}, 32'(done), 32'd0);
    #10;
    chk({tag, " R5 idle"}, 32'(cs_n), 32'h1f);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; ale = 1'b0; rdy = 1'b0;
    cs_fast = 1'b1; space_sel = 2'd0; can_en = 1'b0;
    for (int k = 0; k < 4; k++) begin bbase[k] = 0; bsize[k] = 0; ben[k] = 0; end
    for (int k = 0; k < 5; k++) begin bwait[k] = 0; ren[k] = 0; rpol[k] = 0; end
    apply_cfg();
    repeat (3) @(posedge clk);
    #5;
    chk("R12 cs in reset", 32'(cs_n), 32'h1f);
    chk("R12 done in reset", 32'(done), 32'd0);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5;
    chk("R12 cs after reset", 32'(cs_n), 32'h1f);
    chk("R12 done after reset", 32'(done), 32'd0);

    // layout A: nested windows inside each pair
    bbase = '{32'h010, 32'h018, 32'h040, 32'h050};
    bsize = '{4, 3, 6, 2};
    ben   = '{1, 1, 1, 1};
    bwait = '{1, 0, 2, 1, 0};
    apply_cfg();
    for (int k = 0; k < 512; k++) begin
      cs_fast = k[0];
      do_access(24'(k * 32'h800 + 32'h35), 0, -1, 24'h0, "R1 R3 layoutA");
    end

    // layout B: cross-pair overlap and whole-space window
    bbase = '{32'h000, 32'h800, 32'h400, 32'h000};
    bsize = '{11, 12, 8, 0};
    ben   = '{1, 1, 1, 0};
    bwait = '{0, 1, 0, 3, 2};
    apply_cfg();
    cs_fast = 1'b1;
    for (int k = 0; k < 64; k++) begin
      do_access(24'(k * 32'h40000 + 32'h1ff), 0, -1, 24'h0, "R1 R4 layoutB");
    end

    // layout C: everything disabled, bases still covering the addresses
    ben = '{0, 0, 0, 0};
    bwait = '{0, 0, 0, 0, 1};
    apply_cfg();
    for (int k = 0; k < 8; k++) begin
      do_access(24'(k * 32'h1234 + 32'h400000), 0, -1, 24'h0, "R2 default");
    end

    // ready handling on window 2 and the default set
    ben   = '{1, 1, 0, 0};
    bbase = '{32'h100, 32'h200, 32'h000, 32'h000};
    bsize = '{0, 0, 0, 0};
    bwait = '{0, 2, 0, 0, 1};
    ren   = '{0, 1, 0, 0, 0};
    rpol  = '{0, 1, 0, 0, 1};
    apply_cfg();
    do_access(24'h200010, 3, -1, 24'h0, "R8 high level");
    cs_fast = 1'b0;
    do_access(24'h200020, 1, -1, 24'h0, "R8 high level late");
    rpol[1] = 1'b0;
    apply_cfg();
    do_access(24'h200030, 2, -1, 24'h0, "R8 low level");
    cs_fast = 1'b1;
    do_access(24'h200040, 0, -1, 24'h0, "R8 ready already active");
    do_access(24'h900000, 5, -1, 24'h0, "R8 default ignores ready");

    // second strobe during an access
    bwait[4] = 4;
    bbase[3] = 32'h700; bsize[3] = 4; ben[3] = 1'b1;
    apply_cfg();
    do_access(24'h900000, 0, 1, 24'h700100, "R9 strobe ignored");
    cs_fast = 1'b0;
    do_access(24'h900000, 0, 2, 24'h700200, "R9 strobe ignored late");
    cs_fast = 1'b1;
    do_access(24'h700300, 0, -1, 24'h0, "R9 window after");

    // segment line count
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 2; c++) begin
        int n;
        space_sel = 2'(s);
        can_en = c[0];
        n = (s == 0) ? 8 : (s == 1) ? 4 : (s == 2) ? 2 : 0;
        if (c == 1 && n > 4) n = 4;
        #4;
        chk((c == 1) ? "R11 seg lines shared" : "R10 seg lines", 32'(seg_lines), 32'(n));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule